// File: doc/BRIEF.md
# Line output power sequencer

This block orders the two control levels of an audio line-output stage, a power enable and a power-save flag, so that the output rises to or falls from its common-mode level without an audible pop. A single enable request says whether the output should be on or off. The block works out the step order from that request. Before every change of the power enable it raises power-save. After the change it holds power-save for a long settling interval. The interval is counted in clock cycles, and power-save is released only when it has run out.

The settling interval comes from the clock frequency and a time in milliseconds. By default it covers a worst case of 300 ms, against a typical settle of 200 ms. A simulation can override the cycle count with a short value. Three status outputs report the state of the output: busy while a sequence runs, active in normal operation, and off when fully powered down. If the request changes while a sequence runs, the sequence still runs to its end. The request level held at that point then decides whether a reverse sequence follows.

Top module: `lineout_pwr_seq`

## Requirements
- R1: While reset is held and after it is released with `en_req` low, `pwr_en`, `psave`, `busy` and `out_active` are 0 and `out_off` is 1.
- R2: `en_req` is sampled into one register stage. A change of `en_req` applied before clock edge t+1 is acted on at edge t+2, the first step of the resulting sequence.
- R3: Power-up order. `psave` rises at edge t+2. `pwr_en` rises at edge t+3. `psave` falls at edge t+3+SETTLE_CYCLES.
- R4: Power-down order. `psave` rises at edge t+2. `pwr_en` falls at edge t+3. `psave` falls at edge t+3+SETTLE_CYCLES.
- R5: After every change of `pwr_en`, `psave` stays high for exactly SETTLE_CYCLES cycles. By default SETTLE_CYCLES = CLK_HZ/1000*SETTLE_MS, which is 37,500,000 cycles (300 ms) at 125 MHz.
- R6: `psave` and `pwr_en` never change in the same cycle. `pwr_en` changes only while `psave` is high in both the cycle before and the cycle after the change.
- R7: `out_active` is 1 exactly when `pwr_en`=1 and `psave`=0. `out_off` is 1 exactly when `pwr_en`=0 and `psave`=0.
- R8: `busy` is 1 from the edge where `psave` rises until the edge where it falls, so `busy` equals `psave` in every cycle.
- R9: A running sequence is never aborted. If `en_req` holds the opposite level when a sequence ends (it changed at any point up to the edge that ends the sequence), the reverse sequence starts at the next edge.
- R10: If `en_req` leaves its level during a sequence and returns to it before the sequence ends, no reverse sequence follows. The outputs stay in the final state of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 1 | Requested output level: 1 on, 0 off |
| pwr_en | output | 1 | Power enable to the output stage |
| psave | output | 1 | Power-save flag to the output stage |
| busy | output | 1 | A power sequence is running |
| out_active | output | 1 | Output in normal operation |
| out_off | output | 1 | Output fully powered down |

## Verification
The assertions assume that `en_req` is synchronous to `clk` and that reset is held for at least two edges, so that every `$past` value they use comes from a defined state. They also assume SETTLE_CYCLES is at least 2, so that the enable step and the release step of one sequence never fall on neighbouring edges. The stimulus changes `en_req` only on falling clock edges and builds the design with a settling count of 4. It sweeps the reversing request across every cycle offset from the first step to the final edge of a sequence, in both directions.

// File: rtl/lps_pkg.sv
// Package: shared types of the line-output power sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package lps_pkg;

    // Sequencer states; each one fixes the levels of both control outputs.
    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_UP_SAVE   = 3'd1,
        ST_UP_SETTLE = 3'd2,
        ST_ON        = 3'd3,
        ST_DN_SAVE   = 3'd4,
        ST_DN_SETTLE = 3'd5
    } seq_state_t;

endpackage

// File: rtl/lps_req_latch.sv
// Module: lps_req_latch
// Registers the enable request once, so the sequencer sees a clean level.
// The level it holds when a sequence ends decides the next sequence.
// Assumes: en_req is synchronous to clk.
module lps_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    output logic req_q
);

    // Sample the requested level every cycle; reset requests "off".
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= en_req;
    end

endmodule

// File: rtl/lps_settle_timer.sv
// Module: lps_settle_timer
// Down-counter for the settling interval. A load makes the next CYCLES
// cycles of run count down, and expired is high in the last of them.
// Assumes: CYCLES >= 1; load and run are never high together.
module lps_settle_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    localparam int W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

    logic [W-1:0] cnt_q;

    // Load the interval, then step down to zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= W'(CYCLES - 1);
        else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // Zero count marks the final cycle of the interval.
    always_comb expired = (cnt_q == '0);

endmodule

// File: rtl/lps_seq_fsm.sv
// Module: lps_seq_fsm
// Steps psave and pwr_en one at a time, with psave held high around every
// enable change until the settle timer runs out. Never aborts a sequence.
// Assumes: expired comes from lps_settle_timer loaded by this module's load.
module lps_seq_fsm
    import lps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_q,
    input  logic expired,
    output logic load,
    output logic run,
    output logic pwr_en,
    output logic psave,
    output logic busy,
    output logic out_active,
    output logic out_off
);

    seq_state_t state_q, state_d;

    // Hold the state register; reset lands in the powered-down state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Choose the next step; idle states look at the request only.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:       if (req_q)   state_d = ST_UP_SAVE;
            ST_UP_SAVE:                state_d = ST_UP_SETTLE;
            ST_UP_SETTLE: if (expired) state_d = ST_ON;
            ST_ON:        if (!req_q)  state_d = ST_DN_SAVE;
            ST_DN_SAVE:                state_d = ST_DN_SETTLE;
            ST_DN_SETTLE: if (expired) state_d = ST_OFF;
            default:                   state_d = ST_OFF;
        endcase
    end

    // Decode control levels, timer controls and status from the state.
    always_comb begin
        psave      = (state_q == ST_UP_SAVE) || (state_q == ST_UP_SETTLE) ||
                     (state_q == ST_DN_SAVE) || (state_q == ST_DN_SETTLE);
        pwr_en     = (state_q == ST_UP_SETTLE) || (state_q == ST_ON) ||
                     (state_q == ST_DN_SAVE);
        load       = (state_q == ST_UP_SAVE) || (state_q == ST_DN_SAVE);
        run        = (state_q == ST_UP_SETTLE) || (state_q == ST_DN_SETTLE);
        busy       = (state_q != ST_OFF) && (state_q != ST_ON);
        out_active = (state_q == ST_ON);
        out_off    = (state_q == ST_OFF);
    end

    AST_ONE_STEP_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !((psave != $past(psave)) && (pwr_en != $past(pwr_en)))); // R6

    AST_EN_UNDER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en != $past(pwr_en)) |-> (psave && $past(psave))); // R6

    AST_RELEASE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psave) |-> $past(expired)); // R5

    AST_ACTIVE_NORMAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        out_active |-> (pwr_en && !psave)); // R7

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_off |-> (!pwr_en && !psave && !busy)); // R7

    AST_BUSY_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(psave)); // R8

endmodule

// File: rtl/lineout_pwr_seq.sv
// Module: lineout_pwr_seq (top)
// Pop-free power sequencer for a line output: request register, step
// machine and settle timer. SETTLE_CYCLES defaults to SETTLE_MS at CLK_HZ.
// Assumes: en_req synchronous to clk; SETTLE_CYCLES >= 2.
module lineout_pwr_seq #(
    parameter int CLK_HZ        = 125_000_000,
    parameter int SETTLE_MS     = 300,
    parameter int SETTLE_CYCLES = CLK_HZ / 1000 * SETTLE_MS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    output logic pwr_en,
    output logic psave,
    output logic busy,
    output logic out_active,
    output logic out_off
);

    logic req_q;
    logic tmr_load;
    logic tmr_run;
    logic tmr_expired;

    lps_req_latch u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_req (en_req),
        .req_q  (req_q)
    );

    lps_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    lps_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_q      (req_q),
        .expired    (tmr_expired),
        .load       (tmr_load),
        .run        (tmr_run),
        .pwr_en     (pwr_en),
        .psave      (psave),
        .busy       (busy),
        .out_active (out_active),
        .out_off    (out_off)
    );

endmodule

// File: tb/lineout_pwr_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps the reversing request over every cycle offset of a
// sequence in both directions, with step cycles computed from N.
module lineout_pwr_seq_tb_top;

    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_req = 1'b0;
    logic pwr_en, psave, busy, out_active, out_off;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic ps_prev = 1'b0, en_prev = 1'b0;

    always #4 clk = ~clk;

    // Count rising edges; a negedge sample at cyc==c sees the state after edge c.
    always @(posedge clk) cyc <= cyc + 1;

    lineout_pwr_seq #(.SETTLE_CYCLES(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_req     (en_req),
        .pwr_en     (pwr_en),
        .psave      (psave),
        .busy       (busy),
        .out_active (out_active),
        .out_off    (out_off)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic at_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Per-cycle invariants on the status and step outputs.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 single step", int'((psave != ps_prev) && (pwr_en != en_prev)), 0);
            chk("R7 out_active", int'(out_active), int'(pwr_en && !psave));
            chk("R7 out_off", int'(out_off), int'(!pwr_en && !psave));
            chk("R8 busy", int'(busy), int'(psave));
        end
        ps_prev <= psave;
        en_prev <= pwr_en;
    end

    // Checks one sequence toward level dir whose request was applied at cycle s.
    task automatic expect_phase(input bit dir, input int s);
        at_cyc(s + 1);
        chk("R2 no step yet", int'(psave), 0);
        chk("R2 old enable", int'(pwr_en), int'(!dir));
        at_cyc(s + 2);
        chk("R3/R4 psave first", int'(psave), 1);
        chk("R3/R4 enable held", int'(pwr_en), int'(!dir));
        at_cyc(s + 3);
        chk(dir ? "R3 enable rise" : "R4 enable fall", int'(pwr_en), int'(dir));
        chk("R5 psave held", int'(psave), 1);
        at_cyc(s + 2 + N);
        chk("R5 psave still held", int'(psave), 1);
        at_cyc(s + 3 + N);
        chk("R5 psave released", int'(psave), 0);
        chk("R9 enable level kept", int'(pwr_en), int'(dir));
        chk("R7 active at end", int'(out_active), int'(dir));
    endtask

    // Sequence toward dir, with the request reversed d cycles after s.
    task automatic reverse_case(input bit dir, input int d);
        int s;
        @(negedge clk);
        s = cyc;
        en_req = dir;
        fork
            begin
                at_cyc(s + d);
                en_req = !dir;
            end
            begin
                expect_phase(dir, s);
                expect_phase(!dir, s + N + 2);   // R9 reverse follows
            end
        join
        repeat (3) @(negedge clk);
    endtask

    // Sequence toward dir with a request glitch that returns before the end.
    task automatic bounce_case(input bit dir);
        int s;
        @(negedge clk);
        s = cyc;
        en_req = dir;
        fork
            begin
                at_cyc(s + 1);
                en_req = !dir;
                at_cyc(s + 2);
                en_req = dir;
            end
            expect_phase(dir, s);
        join
        at_cyc(s + 3 + N + 6);
        chk("R10 no reverse psave", int'(psave), 0);
        chk("R10 enable kept", int'(pwr_en), int'(dir));
        chk("R10 not busy", int'(busy), 0);
    endtask

    task automatic plain_case(input bit dir);
        int s;
        @(negedge clk);
        s = cyc;
        en_req = dir;
        expect_phase(dir, s);
        at_cyc(s + N + 8);
        chk("R9 idle after sequence", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset pwr_en", int'(pwr_en), 0);
        chk("R1 reset psave", int'(psave), 0);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset out_off", int'(out_off), 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 idle out_off", int'(out_off), 1);
        chk("R1 idle out_active", int'(out_active), 0);
        chk("R1 idle pwr_en", int'(pwr_en), 0);

        plain_case(1'b1);
        plain_case(1'b0);
        for (int d = 1; d <= N + 2; d++) reverse_case(1'b1, d);
        plain_case(1'b1);
        for (int d = 1; d <= N + 2; d++) reverse_case(1'b0, d);
        bounce_case(1'b0);
        bounce_case(1'b1);
        plain_case(1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule